// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block decides when a DDR SDRAM controller should spend a command slot on an AUTO REFRESH. An interval counter marks one refresh as owed every `INTERVAL_CYC` clock cycles. The block keeps a running count of owed refreshes. While that count is non-zero it asks the command arbiter for a slot. The arbiter may leave the refresh waiting while the memory is busy with traffic and pay the backlog off later.

The request is low-priority at first. While `busy_i` is high it is withheld, so that data traffic goes first. When the backlog reaches `MAX_OWED` (eight by default), the block raises `urgent_o`. From then on the request is forced high whatever `busy_i` says, and the arbiter must grant at its next opportunity.

Each accepted grant pays off one owed refresh. It also starts a refresh-cycle timer of `TRFC_CYC` cycles. While that timer runs, `cke_hold_o` tells the power logic to keep the clock enable high, and no new request is raised. With the defaults of 1302 cycles per interval and 12 cycles of refresh time, a 166 MHz memory receives 8192 refreshes per 64 ms. No refresh is deferred by more than eight intervals.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `req_o`, `urgent_o` and `cke_hold_o` are all 0 and no refresh is owed.
- R2: One refresh becomes owed at each interval boundary. The first boundary is the `INTERVAL_CYC`-th rising edge after reset release, and further boundaries follow every `INTERVAL_CYC` edges. The new owed count is visible on the outputs in the cycle after that edge.
- R3: `req_o` is 1 exactly when all three of these hold: at least one refresh is owed, no refresh-cycle timer is running, and either `busy_i` was 0 at the last rising edge or the backlog is full.
- R4: While `busy_i` is held at 1 and the backlog is below `MAX_OWED`, `req_o` stays 0.
- R5: `urgent_o` is 1 exactly when the owed count equals `MAX_OWED` and no refresh-cycle timer is running. Whenever `urgent_o` is 1, `req_o` is 1 as well, even with `busy_i` at 1.
- R6: The owed count never exceeds `MAX_OWED`. An interval boundary that arrives while the count is full is dropped.
- R7: A grant counts only in a cycle where `req_o` is 1, and it lowers the owed count by one. A `gnt_i` pulse while `req_o` is 0 has no effect on any output.
- R8: After an accepted grant, `cke_hold_o` is 1 for exactly `TRFC_CYC` cycles, starting in the next cycle. `req_o` and `urgent_o` are 0 throughout those cycles.
- R9: When an interval boundary and an accepted grant fall on the same edge, the owed count is unchanged.
- R10: If the arbiter grants within one cycle of `urgent_o` rising, two accepted grants are never more than `(MAX_OWED+1)*INTERVAL_CYC` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Arbiter grants the refresh slot this cycle |
| busy_i | input | 1 | Memory has data traffic pending; defers non-urgent requests |
| req_o | output | 1 | A refresh slot is requested |
| urgent_o | output | 1 | Backlog full; the request must be granted at the next opportunity |
| cke_hold_o | output | 1 | Clock enable must be held high; a refresh cycle is in progress |

## Verification
The assertions assume that `gnt_i` and `busy_i` are driven to known levels at every rising edge once reset is released. They also assume that `INTERVAL_CYC` is at least 2 and `TRFC_CYC` is at least 1. The gap bound of R10 also assumes an arbiter that answers `urgent_o` at once. The stimulus keeps within these limits: inputs change only at falling edges, and the random phase always grants in the cycle after `urgent_o` is seen. The one phase that deliberately starves the block of grants to fill the backlog is excluded from the gap measurement.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Registered output bundle of the scheduler
  typedef struct packed {
    logic req;
    logic urg;
    logic cke;
  } refsched_out_t;

  // Largest backlog of deferred refreshes the memory tolerates
  localparam int unsigned MAX_OWED_DEF = 8;

endpackage

// File: rtl/refsched_tick.sv
module refsched_tick #(
  parameter int unsigned INTERVAL_CYC = 1302
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/refsched_owed.sv
module refsched_owed #(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [OW-1:0] owed_n_o,
  output logic [OW-1:0] owed_q_o
);
  localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

  logic [OW-1:0] owed_q;

  always_comb begin
    owed_n_o = owed_q;
    if (inc_i && !dec_i && owed_q != FULL) owed_n_o = owed_q + 1'b1;
    else if (dec_i && !inc_i)              owed_n_o = owed_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_n_o;
  end

  assign owed_q_o = owed_q;

  // R6
  sat_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (owed_q == FULL && inc_i && !dec_i) |=> owed_q == FULL);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    owed_q <= FULL);

  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !inc_i) |=> owed_q == $past(owed_q) - 1'b1);

  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && inc_i) |=> $stable(owed_q));

endmodule

// File: rtl/refsched_rfc.sv
module refsched_rfc #(
  parameter int unsigned TRFC_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic run_n_o
);
  localparam int unsigned RW = $clog2(TRFC_CYC + 1);
  localparam logic [RW-1:0] LOADV = RW'(TRFC_CYC);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_n;

  always_comb begin
    if (load_i)          cnt_n = LOADV;
    else if (cnt_q != 0) cnt_n = cnt_q - 1'b1;
    else                 cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign run_n_o = (cnt_n != 0);

  // R8
  rfc_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != 0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 1302,
  parameter int unsigned TRFC_CYC     = 12,
  parameter int unsigned MAX_OWED     = MAX_OWED_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic gnt_i,
  input  logic busy_i,
  output logic req_o,
  output logic urgent_o,
  output logic cke_hold_o
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

  refsched_out_t out_q;
  logic          tick;
  logic          accept;
  logic          run_n;
  logic [OW-1:0] owed_n;
  logic [OW-1:0] owed_q;
  logic          full_n;

  assign accept = gnt_i && out_q.req;

  refsched_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  refsched_owed #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk      (clk),
    .rst      (rst),
    .inc_i    (tick),
    .dec_i    (accept),
    .owed_n_o (owed_n),
    .owed_q_o (owed_q)
  );

  refsched_rfc #(.TRFC_CYC(TRFC_CYC)) u_rfc (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .run_n_o (run_n)
  );

  assign full_n = (owed_n == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      out_q.cke <= run_n;
      out_q.urg <= full_n && !run_n;
      out_q.req <= (owed_n != 0) && !run_n && (!busy_i || full_n);
    end
  end

  assign req_o      = out_q.req;
  assign urgent_o   = out_q.urg;
  assign cke_hold_o = out_q.cke;

  // R5
  urgent_forces_req_chk: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> req_o);

  // R8
  grant_holds_cke_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_i && req_o) |=> (cke_hold_o && !req_o && !urgent_o));

  // R8
  cke_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    cke_hold_o |-> !req_o);

  // R7
  stray_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_i && !req_o && !cke_hold_o) |=> !cke_hold_o);

  // R3
  req_needs_owed_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> owed_q != 0);

endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int INTERVAL = 50;
  localparam int TRFC     = 4;
  localparam int MAXO     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b0;
  logic busy = 1'b0;
  logic req, urg, cke;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  int m_cnt = 0, m_owed = 0, m_rfc = 0;
  bit e_req = 0, e_urg = 0, e_cke = 0;
  int cyc = 0, last_acc = -1;
  bit gap_on = 0;

  always #10 clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .MAX_OWED(MAXO)) u_dut (
    .clk(clk), .rst(rst), .gnt_i(gnt), .busy_i(busy),
    .req_o(req), .urgent_o(urg), .cke_hold_o(cke)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
    end
  endtask

  function automatic int clamp_inc(input int v);
    return (v < MAXO) ? v + 1 : v;
  endfunction

  // Computes the state after the coming rising edge from the requirements
  task automatic model_edge();
    bit tk, acc;
    tk  = (m_cnt == INTERVAL - 1);                 // R2
    m_cnt = tk ? 0 : m_cnt + 1;
    acc = gnt && e_req;                            // R7
    if (acc) begin
      if (gap_on && last_acc >= 0 && (cyc - last_acc) > (MAXO + 1) * INTERVAL) begin
        n_fail++;
        $display("FAIL R10 grant gap %0d exceeds %0d", cyc - last_acc, (MAXO + 1) * INTERVAL);
      end
      if (gap_on) n_checks++;
      last_acc = cyc;
    end
    if (tk && !acc) m_owed = clamp_inc(m_owed);    // R6
    else if (acc && !tk) m_owed = m_owed - 1;      // R9 when both
    if (acc) m_rfc = TRFC;                         // R8
    else if (m_rfc > 0) m_rfc = m_rfc - 1;
    e_cke = (m_rfc > 0);
    e_urg = (m_owed == MAXO) && (m_rfc == 0);      // R5
    e_req = (m_owed > 0) && (m_rfc == 0) && (!busy || m_owed == MAXO); // R3 R4
  endtask

  // One cycle: check outputs, drive new inputs, advance the model
  task automatic step(input logic g, input logic b);
    @(negedge clk);
    cyc++;
    check("R3 req", req, e_req);
    check("R5 urgent", urg, e_urg);
    check("R8 cke_hold", cke, e_cke);
    gnt  = g;
    busy = b;
    model_edge();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req in reset", req, 1'b0);
    check("R1 urgent in reset", urg, 1'b0);
    check("R1 cke in reset", cke, 1'b0);
    // release reset with a stray grant pending
    rst = 1'b0;
    gnt = 1'b1;
    busy = 1'b0;
    model_edge();

    // R7: grants before any refresh is owed are ignored
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    check("R7 stray grant ignored", cke, 1'b0);
    check("R1 nothing owed early", req, 1'b0);

    // R2/R4/R6: starve the block with busy high until the backlog fills
    for (int i = 0; i < 11 * INTERVAL; i++) step(1'b0, 1'b1);
    check("R6 backlog full urgent", urg, 1'b1);
    check("R5 urgent forces req while busy", req, 1'b1);

    // one grant, then watch the refresh-cycle window
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R8 cke after grant", cke, 1'b1);
    check("R8 req low during tRFC", req, 1'b0);
    for (int i = 0; i < TRFC + 2; i++) step(1'b0, 1'b1);
    check("R4 busy holds back non-urgent req", req, 1'b0);

    // drain with busy low, granting whenever requested
    for (int i = 0; i < 8 * (TRFC + 2) + 10; i++) step(req, 1'b0);

    // R10: random traffic with an arbiter that always answers urgent
    gap_on   = 1;
    last_acc = -1;
    for (int i = 0; i < 20000; i++) begin
      logic g, b;
      b = ($urandom % 100) < 65;
      g = urg ? 1'b1 : (($urandom % 100) < 20);
      step(g, b);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1e5a_77c3));
    #(20 * 60000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule